// File: doc/BRIEF.md
# JTAG Debug Port Scan Target

This block is the scan side of a debug port that sits behind a standard JTAG test access port. A debugger drives TCK, TMS and TDI. The block walks the usual sixteen-state TAP controller and loads a 4-bit instruction. That instruction picks the data register placed between TDI and TDO: a one-bit bypass stage, a fixed identification word, two 35-bit access scans, or a 35-bit abort scan. The debug-port access scan reads and writes a small bank of 32-bit debug-port registers. The access-port scan reaches a stub bank of four 32-bit registers.

Every access scan returns, on TDO, the last posted read result together with a 3-bit acknowledge. An access-port access keeps the port busy for a fixed number of TCK cycles. Any access scan captured in that window answers WAIT, and its request is dropped. An abort scan with its low bit set clears the busy window at once and gives a single-cycle `abort_req` pulse.

Controller states: TAP_RESET (Test-Logic-Reset), TAP_IDLE (Run-Test/Idle), TAP_DR_SEL, TAP_DR_CAP, TAP_DR_SH, TAP_DR_EX1, TAP_DR_PAU, TAP_DR_EX2, TAP_DR_UPD, and the matching TAP_IR_* states. The transitions on TMS are the standard ones:
- RESET→IDLE on 0.
- IDLE→DR_SEL on 1.
- DR_SEL→IR_SEL on 1, or →DR_CAP on 0. IR_SEL→RESET on 1, or →IR_CAP on 0.
- CAP→SH on 0, or →EX1 on 1. SH→SH on 0, or →EX1 on 1.
- EX1→UPD on 1, or →PAU on 0. PAU→PAU on 0, or →EX2 on 1.
- EX2→SH on 0, or →UPD on 1.
- UPD→IDLE on 0, or →DR_SEL on 1.

Top module: `jdp_scan_top`

## Requirements
- R1: Five TCK cycles with TMS high reach Test-Logic-Reset from any state, and TMS high holds it there. Driving trst_n low forces that state asynchronously.
- R2: The instruction register is 4 bits wide and shifts LSB first. Capture-IR loads 0001, so the first bit out is 1. A new code takes effect at Update-IR. Reset selects code 1110.
- R3: Code 1110 places a 32-bit register that captures 0x3BA00477, shifted out LSB first.
- R4: Code 1111, and every code that is not assigned, places a one-bit stage. It captures 0 and delays TDI by one TCK cycle.
- R5: Code 1010 (debug-port access) and code 1011 (access-port access) are 35-bit scans. The incoming request is RnW in bit 0 (1 = read), the address in bits [2:1] and the write data in bits [34:3]. The captured response is the acknowledge in bits [2:0] and the posted read data in bits [34:3]. The acknowledge is 010 (OK) or 001 (WAIT) and never any other value.
- R6: Debug-port address 01 is a read/write control/status register and 10 is a read/write select register. Address 00 reads as zero and ignores writes. Address 11 is the read buffer, and writes to it are ignored.
- R7: Reads are posted. A read delivers its value in the response of the next access scan. A read of address 11 returns the last result again and does not change it.
- R8: The access-port stub holds four 32-bit registers indexed by the address bits. Every accepted access-port request keeps the port busy for AP_BUSY_CYCLES TCK cycles.
- R9: An access scan captured while the port is busy returns WAIT, and its request is discarded.
- R10: Code 1000 is a 35-bit abort scan. At its update, bit 0 = 1 raises abort_req for exactly one TCK cycle and ends the busy window. Bit 0 = 0 has no effect, and bits [34:1] are ignored.
- R11: Test-Logic-Reset clears the control/status and select registers, the read buffer, the access-port registers and the busy window. It also selects code 1110.
- R12: tdo shows bit 0 of the active shift stage only in Shift-IR and Shift-DR. In every other state it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, steers the TAP controller |
| tdi | input | 1 | Serial data in, shifted in LSB first |
| tdo | output | 1 | Serial data out |
| abort_req | output | 1 | One-cycle pulse requesting an abort of the access in progress |

## Verification
Some checks run on every cycle: the controller holds in reset while TMS is high, the instruction stays fixed outside Update-IR and reset, and every captured acknowledge is a legal code. Others cover the abort path: the abort pulse lasts one cycle and leaves the port idle, and a WAIT-answered update leaves the read buffer unchanged. Other behaviour shows only through complete scan sequences. This covers posted read timing, read-buffer reuse, discarded writes that reappear later as old data, TMS-driven and trst_n-driven reset clearing the register bank, and the one-cycle delay through the bypass stage.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

    localparam int IR_W    = 4;
    localparam int ACC_W   = 35;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int AP_REGS = 2 ** ADDR_W;

    localparam logic [IR_W-1:0] IR_BYPASS = 4'b1111;
    localparam logic [IR_W-1:0] IR_IDCODE = 4'b1110;
    localparam logic [IR_W-1:0] IR_DPACC  = 4'b1010;
    localparam logic [IR_W-1:0] IR_APACC  = 4'b1011;
    localparam logic [IR_W-1:0] IR_ABORT  = 4'b1000;
    localparam logic [IR_W-1:0] IR_CAPVAL = 4'b0001;

    localparam logic [WORD_W-1:0] ID_WORD = 32'h3BA0_0477;

    localparam logic [2:0] ACK_WAIT = 3'b001;
    localparam logic [2:0] ACK_OK   = 3'b010;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        TAP_DR_SEL, TAP_DR_CAP, TAP_DR_SH, TAP_DR_EX1, TAP_DR_PAU, TAP_DR_EX2, TAP_DR_UPD,
        TAP_IR_SEL, TAP_IR_CAP, TAP_IR_SH, TAP_IR_EX1, TAP_IR_PAU, TAP_IR_EX2, TAP_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] { K_BYP, K_ID, K_ACC, K_ABT } dr_kind_e;

    function automatic dr_kind_e kind_of(input logic [IR_W-1:0] code);
        unique case (code)
            IR_IDCODE:          return K_ID;
            IR_DPACC, IR_APACC: return K_ACC;
            IR_ABORT:           return K_ABT;
            default:            return K_BYP;
        endcase
    endfunction

endpackage

// File: rtl/jdp_tap_fsm.sv
module jdp_tap_fsm
    import jdp_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e st
);

    tap_state_e nx;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st <= TAP_RESET;
        else         st <= nx;
    end

    always_comb begin
        unique case (st)
            TAP_RESET:  nx = tms ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   nx = tms ? TAP_DR_SEL : TAP_IDLE;
            TAP_DR_SEL: nx = tms ? TAP_IR_SEL : TAP_DR_CAP;
            TAP_DR_CAP: nx = tms ? TAP_DR_EX1 : TAP_DR_SH;
            TAP_DR_SH:  nx = tms ? TAP_DR_EX1 : TAP_DR_SH;
            TAP_DR_EX1: nx = tms ? TAP_DR_UPD : TAP_DR_PAU;
            TAP_DR_PAU: nx = tms ? TAP_DR_EX2 : TAP_DR_PAU;
            TAP_DR_EX2: nx = tms ? TAP_DR_UPD : TAP_DR_SH;
            TAP_DR_UPD: nx = tms ? TAP_DR_SEL : TAP_IDLE;
            TAP_IR_SEL: nx = tms ? TAP_RESET  : TAP_IR_CAP;
            TAP_IR_CAP: nx = tms ? TAP_IR_EX1 : TAP_IR_SH;
            TAP_IR_SH:  nx = tms ? TAP_IR_EX1 : TAP_IR_SH;
            TAP_IR_EX1: nx = tms ? TAP_IR_UPD : TAP_IR_PAU;
            TAP_IR_PAU: nx = tms ? TAP_IR_EX2 : TAP_IR_PAU;
            TAP_IR_EX2: nx = tms ? TAP_IR_UPD : TAP_IR_SH;
            TAP_IR_UPD: nx = tms ? TAP_DR_SEL : TAP_IDLE;
            default:    nx = TAP_RESET;
        endcase
    end

    // R1: TMS high keeps the controller parked in reset
    a_r1_tms_holds_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TAP_RESET && tms) |=> st == TAP_RESET);

    // R1: IR select with TMS high enters reset
    a_r1_irsel_to_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TAP_IR_SEL && tms) |=> st == TAP_RESET);

endmodule

// File: rtl/jdp_reg_bank.sv
module jdp_reg_bank
    import jdp_pkg::*;
#(
    parameter int AP_BUSY_CYCLES = 200
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tlr,
    input  logic              req_valid,
    input  logic              req_ap,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rnw,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              abort_valid,
    output logic              busy,
    output logic [WORD_W-1:0] rd_post,
    output logic              abort_req
);

    localparam int CNT_W = $clog2(AP_BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(AP_BUSY_CYCLES);

    logic [CNT_W-1:0]  busy_cnt;
    logic [WORD_W-1:0] ctrl_q, sel_q, dp_rd;
    logic [WORD_W-1:0] ap_q [AP_REGS];

    assign busy = (busy_cnt != '0);

    always_comb begin
        unique case (req_addr)
            2'b01:   dp_rd = ctrl_q;
            2'b10:   dp_rd = sel_q;
            2'b11:   dp_rd = rd_post;
            default: dp_rd = '0;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            busy_cnt  <= '0;
            ctrl_q    <= '0;
            sel_q     <= '0;
            rd_post   <= '0;
            abort_req <= 1'b0;
        end else if (tlr) begin
            busy_cnt  <= '0;
            ctrl_q    <= '0;
            sel_q     <= '0;
            rd_post   <= '0;
            abort_req <= 1'b0;
        end else begin
            abort_req <= abort_valid;
            if (abort_valid)
                busy_cnt <= '0;
            else if (req_valid && req_ap)
                busy_cnt <= CNT_LOAD;
            else if (busy)
                busy_cnt <= busy_cnt - 1'b1;
            if (req_valid && req_rnw)
                rd_post <= req_ap ? ap_q[req_addr] : dp_rd;
            if (req_valid && !req_rnw && !req_ap) begin
                if (req_addr == 2'b01) ctrl_q <= req_wdata;
                if (req_addr == 2'b10) sel_q  <= req_wdata;
            end
        end
    end

    for (genvar g = 0; g < AP_REGS; g++) begin : g_ap
        always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)
                ap_q[g] <= '0;
            else if (tlr)
                ap_q[g] <= '0;
            else if (req_valid && req_ap && !req_rnw && req_addr == ADDR_W'(g))
                ap_q[g] <= req_wdata;
        end
    end

    // R10: the abort pulse lasts a single cycle
    a_r10_pulse_single: assert property (@(posedge tck) disable iff (!trst_n)
        abort_req |=> !abort_req);

    // R10: an abort leaves the port idle
    a_r10_abort_clears_busy: assert property (@(posedge tck) disable iff (!trst_n)
        abort_req |-> !busy);

    // R8: an accepted access-port request opens the busy window
    a_r8_ap_sets_busy: assert property (@(posedge tck) disable iff (!trst_n)
        (req_valid && req_ap && !abort_valid && !tlr) |=> busy);

endmodule

// File: rtl/jdp_scan_top.sv
module jdp_scan_top
    import jdp_pkg::*;
#(
    parameter int AP_BUSY_CYCLES = 200
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic abort_req
);

    tap_state_e        st;
    dr_kind_e          kind;
    logic [IR_W-1:0]   ir_q, ir_sr;
    logic [ACC_W-1:0]  dr_sr, cap_val, sh_val;
    logic              scan_waited, busy, upd_dr;
    logic              req_valid, abort_valid;
    logic [WORD_W-1:0] rd_post;

    jdp_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .st     (st)
    );

    assign kind = kind_of(ir_q);

    always_comb begin
        unique case (kind)
            K_ID:    cap_val = {3'b000, ID_WORD};
            K_ACC:   cap_val = {rd_post, busy ? ACK_WAIT : ACK_OK};
            default: cap_val = '0;
        endcase
        unique case (kind)
            K_BYP:   sh_val = {{(ACC_W-1){1'b0}}, tdi};
            K_ID:    sh_val = {3'b000, tdi, dr_sr[WORD_W-1:1]};
            default: sh_val = {tdi, dr_sr[ACC_W-1:1]};
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q        <= IR_IDCODE;
            ir_sr       <= '0;
            dr_sr       <= '0;
            scan_waited <= 1'b0;
        end else begin
            unique case (st)
                TAP_RESET:  ir_q  <= IR_IDCODE;
                TAP_IR_CAP: ir_sr <= IR_CAPVAL;
                TAP_IR_SH:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                TAP_IR_UPD: ir_q  <= ir_sr;
                TAP_DR_CAP: begin
                    dr_sr       <= cap_val;
                    scan_waited <= (kind == K_ACC) && busy;
                end
                TAP_DR_SH:  dr_sr <= sh_val;
                default: ;
            endcase
        end
    end

    assign upd_dr      = (st == TAP_DR_UPD);
    assign req_valid   = upd_dr && (kind == K_ACC) && !scan_waited;
    assign abort_valid = upd_dr && (kind == K_ABT) && dr_sr[0];

    always_comb begin
        unique case (st)
            TAP_DR_SH: tdo = dr_sr[0];
            TAP_IR_SH: tdo = ir_sr[0];
            default:   tdo = 1'b0;
        endcase
    end

    jdp_reg_bank #(.AP_BUSY_CYCLES(AP_BUSY_CYCLES)) u_bank (
        .tck         (tck),
        .trst_n      (trst_n),
        .tlr         (st == TAP_RESET),
        .req_valid   (req_valid),
        .req_ap      (ir_q == IR_APACC),
        .req_addr    (dr_sr[2:1]),
        .req_rnw     (dr_sr[0]),
        .req_wdata   (dr_sr[ACC_W-1:3]),
        .abort_valid (abort_valid),
        .busy        (busy),
        .rd_post     (rd_post),
        .abort_req   (abort_req)
    );

    // R5: a captured acknowledge is only OK or WAIT
    a_r5_ack_legal: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TAP_DR_CAP && kind == K_ACC) |=> (dr_sr[2:0] == ACK_OK || dr_sr[2:0] == ACK_WAIT));

    // R3: the identification capture holds the fixed word
    a_r3_id_capture: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TAP_DR_CAP && kind == K_ID) |=> dr_sr[WORD_W-1:0] == ID_WORD);

    // R2: the instruction changes only at Update-IR or reset
    a_r2_ir_stable: assert property (@(posedge tck) disable iff (!trst_n)
        (st != TAP_IR_UPD && st != TAP_RESET) |=> $stable(ir_q));

    // R9: a WAIT-answered update does not touch the read buffer
    a_r9_wait_discards: assert property (@(posedge tck) disable iff (!trst_n)
        (upd_dr && kind == K_ACC && scan_waited) |=> $stable(rd_post));

endmodule

// File: tb/tb_jdp_scan_top.sv
module tb_jdp_scan_top;

    localparam int AP_BUSY = 200;
    localparam int NV = 14;

    // {ir[3:0], shifted request[34:0], expected capture[34:0]}
    localparam logic [73:0] VEC [NV] = '{
        {4'hE, 35'h0, 3'b000, 32'h3BA00477},
        {4'hA, 32'h12345678, 2'b01, 1'b0, 32'h0, 3'b010},
        {4'hA, 32'hA5A50F0F, 2'b10, 1'b0, 32'h0, 3'b010},
        {4'hA, 32'h0, 2'b01, 1'b1, 32'h0, 3'b010},
        {4'hA, 32'h0, 2'b10, 1'b1, 32'h12345678, 3'b010},
        {4'hA, 32'h0, 2'b11, 1'b1, 32'hA5A50F0F, 3'b010},
        {4'hA, 32'h0, 2'b11, 1'b1, 32'hA5A50F0F, 3'b010},
        {4'hA, 32'hFFFFFFFF, 2'b00, 1'b0, 32'hA5A50F0F, 3'b010},
        {4'hA, 32'h0, 2'b00, 1'b1, 32'hA5A50F0F, 3'b010},
        {4'hA, 32'h0, 2'b11, 1'b1, 32'h0, 3'b010},
        {4'hA, 32'h0000DEAD, 2'b11, 1'b0, 32'h0, 3'b010},
        {4'hA, 32'h0, 2'b11, 1'b1, 32'h0, 3'b010},
        {4'hA, 32'h0, 2'b01, 1'b1, 32'h0, 3'b010},
        {4'hA, 32'h0, 2'b11, 1'b1, 32'h12345678, 3'b010}
    };

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, abort_req;
    int   checks = 0, errors = 0, abort_hits = 0;
    bit   done = 1'b0;

    jdp_scan_top #(.AP_BUSY_CYCLES(AP_BUSY)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .abort_req(abort_req)
    );

    always #2 tck = ~tck;

    task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        o = tdo;
        if (abort_req) abort_hits++;
        tms = m;
        tdi = d;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        tick(1'b1, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, code[i], o);
            cap[i] = o;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int len, input logic [34:0] din, output logic [34:0] dout);
        logic o;
        dout = '0;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o);
            dout[i] = o;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    initial begin
        repeat (50000) @(posedge tck);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0]  icap;
        logic [34:0] dout;
        logic [3:0]  code;
        logic        o;
        int          h0;

        // reset state (R11, R12)
        repeat (3) @(negedge tck);
        chk("R12 tdo in reset", {34'b0, tdo}, 35'h0);
        chk("R11 abort_req in reset", {34'b0, abort_req}, 35'h0);
        trst_n = 1'b1;
        tick(1'b0, 1'b0, o);
        idle(2);
        chk("R12 tdo in idle", {34'b0, tdo}, 35'h0);

        // table walk: R3 identification, R5/R6/R7 debug-port accesses
        for (int k = 0; k < NV; k++) begin
            code = VEC[k][73:70];
            scan_ir(code, icap);
            scan_dr(code == 4'hE ? 32 : 35, VEC[k][69:35], dout);
            chk(k == 0 ? "R3 idcode vector" : "R5/R6/R7 access vector", dout, VEC[k][34:0]);
        end

        // R2 instruction capture pattern, R4 bypass delay
        scan_ir(4'hF, icap);
        chk("R2 ir capture", {31'b0, icap}, 35'h1);
        scan_dr(8, 35'hB5, dout);
        chk("R4 bypass delay", dout, 35'h6A);
        scan_ir(4'h0, icap);
        scan_dr(8, 35'hB5, dout);
        chk("R4 unassigned code acts as bypass", dout, 35'h6A);

        // R8/R9 access-port busy window
        scan_ir(4'hB, icap);
        scan_dr(35, {32'hCAFEF00D, 2'b10, 1'b0}, dout);
        chk("R8 ap write ack", {32'h0, dout[2:0]}, 35'h2);
        scan_dr(35, {32'h11111111, 2'b10, 1'b0}, dout);
        chk("R9 busy scan answers wait", {32'h0, dout[2:0]}, 35'h1);
        idle(AP_BUSY + 60);
        scan_dr(35, {32'h0, 2'b10, 1'b1}, dout);
        chk("R7 ap read returns previous result", dout, {32'h12345678, 3'b010});
        idle(AP_BUSY + 60);
        scan_ir(4'hA, icap);
        scan_dr(35, {32'h0, 2'b11, 1'b1}, dout);
        chk("R9 discarded write, R8 stored word", dout, {32'hCAFEF00D, 3'b010});

        // R10 abort
        scan_ir(4'hB, icap);
        scan_dr(35, {32'h0, 2'b01, 1'b0}, dout);
        scan_ir(4'h8, icap);
        h0 = abort_hits;
        scan_dr(35, 35'h7FFFFFFFE, dout);
        idle(2);
        chk("R10 bit0 clear gives no pulse", 35'(abort_hits - h0), 35'h0);
        scan_ir(4'hA, icap);
        scan_dr(35, {32'h0, 2'b11, 1'b1}, dout);
        chk("R10 bit0 clear leaves port busy", dout, {32'hCAFEF00D, 3'b001});
        scan_ir(4'h8, icap);
        h0 = abort_hits;
        scan_dr(35, 35'h1, dout);
        idle(3);
        chk("R10 single abort pulse", 35'(abort_hits - h0), 35'h1);
        scan_ir(4'hA, icap);
        scan_dr(35, {32'h0, 2'b11, 1'b1}, dout);
        chk("R10 ok after abort", dout, {32'hCAFEF00D, 3'b010});

        // R1/R11 TMS-driven reset
        scan_dr(35, {32'h0BADF00D, 2'b01, 1'b0}, dout);
        scan_ir(4'hF, icap);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        scan_dr(32, 35'h0, dout);
        chk("R1 tms reset selects idcode", dout, 35'h3BA00477);
        scan_ir(4'hA, icap);
        scan_dr(35, {32'h0, 2'b01, 1'b1}, dout);
        chk("R11 read buffer cleared", dout, {32'h0, 3'b010});
        scan_dr(35, {32'h0, 2'b11, 1'b1}, dout);
        chk("R11 control register cleared", dout, {32'h0, 3'b010});

        // R1 asynchronous trst_n
        scan_ir(4'hF, icap);
        @(negedge tck);
        #1 trst_n = 1'b0;
        #4 trst_n = 1'b1;
        tms = 1'b0;
        scan_dr(32, 35'h0, dout);
        chk("R1 trst_n selects idcode", dout, 35'h3BA00477);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule